// File: doc/BRIEF.md
# Chunked Firmware DMA Loader

This block sequences the DMA commands that copy one firmware region into a local instruction or data memory. The region always moves in 256-byte chunks. A single-cycle `start` pulse hands it a source base address, a source start offset, a destination start offset, a byte length, a target select and a secure flag. All of these are captured on that cycle.

The block first forms the effective base and checks alignment. It then presents the base as two fields and issues one chunk command per 256 bytes, raising the offsets by 256 each time. After every command it waits for the DMA engine to report idle before it issues the next one. A bounded wait, counted in clock cycles, aborts the load if idle never comes back.

The source offset is handled differently for the two targets. An instruction-memory load keeps the base as given and sends the start offset in each chunk's source offset, where it serves as an address tag. A data-memory load adds the start offset into the base and sends chunk source offsets that count from zero.

The controller is a five-state machine:
- IDLE → CHECK on `start`.
- CHECK → FINISH on rejection or zero length; otherwise CHECK → ISSUE.
- ISSUE → WAIT always.
- WAIT → ISSUE on idle when more chunks remain; WAIT → FINISH on idle after the last chunk, or on timeout.
- FINISH → IDLE always.

Top module: `fw_chunk_loader`

## Requirements
- R1: After reset `busy`, `done` and `cmd_valid` are 0 and `dma_idle` is not needed for anything until a load starts.
- R2: The command word `cmd_word` carries the chunk size code 3'b110 in bits [2:0], the instruction-memory flag in bit 3 and the secure flag in bit 4.
- R3: With `to_imem`=1 the effective base is `src_base` unchanged, and chunk k carries source offset `src_start` + 256·k.
- R4: With `to_imem`=0 the effective base is `src_base` + `src_start`, and chunk k carries source offset 256·k.
- R5: Whenever a command is issued, `base_lo` equals the effective base shifted right by 8 (low 32 bits) and `base_hi` equals it shifted right by 40 (16 bits).
- R6: A load of length L issues exactly L/256 commands in order, and chunk k carries destination offset `dst_start` + 256·k.
- R7: `cmd_valid` is a one-cycle pulse, and after it no further command is issued until `dma_idle` has been seen high in the wait state. The engine drops `dma_idle` in the cycle after a command.
- R8: If the effective base is not a multiple of 256, the load ends with `err_code`=1 and no command is issued.
- R9: If the length is not a multiple of 256, the load ends with `err_code`=2 and no command is issued. A bad base takes priority and reports 1.
- R10: A length of zero ends with `err_code`=0 and no command, with `done` two cycles after the `start` cycle.
- R11: If `dma_idle` stays low for TMO_CYC cycles after a command, the load ends with `err_code`=3. `done` comes TMO_CYC+1 cycles after the command, and no further command is issued.
- R12: Changes to the request inputs after the `start` cycle, and `start` pulses while `busy`, have no effect on the load in progress.
- R13: `busy` is high from the cycle after `start` through the `done` cycle. `done` is a one-cycle pulse and `err_code` is valid with it, coded 0 = success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a load; request fields are sampled in this cycle |
| src_base | input | ADDR_W | Source region base address |
| src_start | input | OFFS_W | Source start offset within the region |
| dst_start | input | OFFS_W | Destination start offset in local memory |
| xfer_len | input | LEN_W | Bytes to copy |
| to_imem | input | 1 | 1 = instruction memory, 0 = data memory |
| secure | input | 1 | Secure flag placed in the command |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 base misaligned, 2 length misaligned, 3 timeout |
| base_lo | output | 32 | Effective base >> 8 |
| base_hi | output | 16 | Effective base >> 40 |
| cmd_valid | output | 1 | One-cycle chunk command strobe |
| cmd_moffs | output | OFFS_W | Destination offset of the chunk |
| cmd_fboffs | output | OFFS_W | Source offset of the chunk |
| cmd_word | output | 5 | Command word (size, target, secure) |
| dma_idle | input | 1 | DMA engine idle |

## Verification
Instruction-memory loads with a nonzero start offset are compared against data-memory loads with a similar request. This separates the two offset paths: the tag shows up in the chunk source offsets in one case and in the base fields in the other. A start offset that is legal for instruction memory but misaligns the folded data-memory base shows that alignment is checked on the effective base. Engine idle delays of one and several cycles confirm that nothing advances without idle. A hung engine checks the exact timeout cycle, and a following good load shows that the block recovers. Inputs disturbed mid-load, plus extra `start` pulses, show that the request was captured once.

// File: rtl/fwl_pkg.sv
package fwl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHECK  = 3'd1,
        ST_ISSUE  = 3'd2,
        ST_WAIT   = 3'd3,
        ST_FINISH = 3'd4
    } fwl_state_e;

    typedef enum logic [1:0] {
        FE_NONE = 2'd0,
        FE_BASE = 2'd1,
        FE_LEN  = 2'd2,
        FE_TMO  = 2'd3
    } fwl_err_e;

    localparam int          CHUNK_LOG2 = 8;
    localparam int          CHUNK_B    = 1 << CHUNK_LOG2;
    localparam logic [2:0]  SIZE_CODE  = 3'b110;
    localparam int          CMD_W      = 5;
endpackage

// File: rtl/fwl_addr_prep.sv
module fwl_addr_prep
    import fwl_pkg::*;
#(
    parameter int ADDR_W = 48,
    parameter int OFFS_W = 32,
    parameter int LEN_W  = 32
) (
    input  logic [ADDR_W-1:0] src_base,
    input  logic [OFFS_W-1:0] src_start,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              to_imem,
    output logic [ADDR_W-1:0] eff_base,
    output logic [OFFS_W-1:0] fb_first,
    output logic              base_bad,
    output logic              len_bad
);
    localparam int EXT_W = (ADDR_W > OFFS_W) ? ADDR_W : OFFS_W;

    logic [EXT_W-1:0] folded;

    always_comb begin
        folded = EXT_W'(src_base) + EXT_W'(src_start);
        if (to_imem) begin
            eff_base = src_base;
            fb_first = src_start;
        end else begin
            eff_base = folded[ADDR_W-1:0];
            fb_first = '0;
        end
        base_bad = |eff_base[CHUNK_LOG2-1:0];
        len_bad  = |xfer_len[CHUNK_LOG2-1:0];
    end
endmodule

// File: rtl/fwl_chunk_ctr.sv
module fwl_chunk_ctr
    import fwl_pkg::*;
#(
    parameter int LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [LEN_W-1:0] len,
    output logic [LEN_W-1:0] pos,
    output logic             last
);
    logic [LEN_W:0] next_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (clr) begin
            pos <= '0;
        end else if (step) begin
            pos <= pos + LEN_W'(CHUNK_B);
        end
    end

    always_comb begin
        next_end = {1'b0, pos} + (LEN_W+1)'(CHUNK_B);
        last     = next_end >= {1'b0, len};
    end

    a_r6_pos_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr) |=> (pos == $past(pos) + LEN_W'(CHUNK_B)));
endmodule

// File: rtl/fwl_idle_timer.sv
module fwl_idle_timer #(
    parameter int TMO_CYC = 100_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(TMO_CYC + 1);
    localparam logic [TW-1:0] LIM = TW'(TMO_CYC - 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (run && cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LIM);

    a_r11_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIM);
endmodule

// File: rtl/fw_chunk_loader.sv
module fw_chunk_loader
    import fwl_pkg::*;
#(
    parameter int ADDR_W  = 48,
    parameter int OFFS_W  = 32,
    parameter int LEN_W   = 32,
    parameter int TMO_CYC = 100_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [OFFS_W-1:0] src_start,
    input  logic [OFFS_W-1:0] dst_start,
    input  logic [LEN_W-1:0]  xfer_len,
    input  logic              to_imem,
    input  logic              secure,
    output logic              busy,
    output logic              done,
    output logic [1:0]        err_code,
    output logic [31:0]       base_lo,
    output logic [15:0]       base_hi,
    output logic              cmd_valid,
    output logic [OFFS_W-1:0] cmd_moffs,
    output logic [OFFS_W-1:0] cmd_fboffs,
    output logic [CMD_W-1:0]  cmd_word,
    input  logic              dma_idle
);
    fwl_state_e        state_q, state_d;
    fwl_err_e          err_q;

    logic [ADDR_W-1:0] eff_c;
    logic [OFFS_W-1:0] fb_c;
    logic              base_bad_c, len_bad_c;

    logic [ADDR_W-1:0] eff_q;
    logic [OFFS_W-1:0] fb_q, dst_q;
    logic [LEN_W-1:0]  len_q;
    logic              imem_q, sec_q, base_bad_q, len_bad_q;

    logic [LEN_W-1:0]  pos;
    logic              last_chunk, tmo;
    logic              in_wait, pos_clr, pos_step, reject;

    fwl_addr_prep #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .LEN_W(LEN_W)) u_prep (
        .src_base (src_base),
        .src_start(src_start),
        .xfer_len (xfer_len),
        .to_imem  (to_imem),
        .eff_base (eff_c),
        .fb_first (fb_c),
        .base_bad (base_bad_c),
        .len_bad  (len_bad_c)
    );

    assign in_wait  = (state_q == ST_WAIT);
    assign pos_clr  = (state_q == ST_CHECK);
    assign pos_step = in_wait && dma_idle;
    assign reject   = base_bad_q || len_bad_q;

    fwl_chunk_ctr #(.LEN_W(LEN_W)) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (pos_clr),
        .step (pos_step),
        .len  (len_q),
        .pos  (pos),
        .last (last_chunk)
    );

    fwl_idle_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (state_q == ST_ISSUE),
        .run    (in_wait && !dma_idle),
        .expired(tmo)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_CHECK;
            ST_CHECK:  begin
                if (reject || len_q == '0) state_d = ST_FINISH;
                else                       state_d = ST_ISSUE;
            end
            ST_ISSUE:  state_d = ST_WAIT;
            ST_WAIT:   begin
                if (dma_idle)  state_d = last_chunk ? ST_FINISH : ST_ISSUE;
                else if (tmo)  state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            err_q      <= FE_NONE;
            eff_q      <= '0;
            fb_q       <= '0;
            dst_q      <= '0;
            len_q      <= '0;
            imem_q     <= 1'b0;
            sec_q      <= 1'b0;
            base_bad_q <= 1'b0;
            len_bad_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                eff_q      <= eff_c;
                fb_q       <= fb_c;
                dst_q      <= dst_start;
                len_q      <= xfer_len;
                imem_q     <= to_imem;
                sec_q      <= secure;
                base_bad_q <= base_bad_c;
                len_bad_q  <= len_bad_c;
                err_q      <= FE_NONE;
            end
            if (state_q == ST_CHECK) begin
                if (base_bad_q)     err_q <= FE_BASE;
                else if (len_bad_q) err_q <= FE_LEN;
            end
            if (in_wait && !dma_idle && tmo) err_q <= FE_TMO;
        end
    end

    // outputs
    always_comb begin
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_FINISH);
        cmd_valid  = (state_q == ST_ISSUE);
        err_code   = err_q;
        base_lo    = 32'(eff_q >> CHUNK_LOG2);
        base_hi    = 16'(eff_q >> 40);
        cmd_moffs  = dst_q + OFFS_W'(pos);
        cmd_fboffs = fb_q + OFFS_W'(pos);
        cmd_word   = {sec_q, imem_q, SIZE_CODE};
    end

    a_r7_cmd_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    a_r7_hold_for_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && !dma_idle && !tmo) |=> (!cmd_valid && in_wait));

    a_r13_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r12_base_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(base_lo) && $stable(base_hi)));

    a_r8_reject_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && reject) |=> (!cmd_valid && done && err_code != 2'd0));
endmodule

// File: tb/sim_fw_chunk_loader.sv
module sim_fw_chunk_loader;
    localparam int ADDR_W = 48;
    localparam int OFFS_W = 32;
    localparam int LEN_W  = 32;
    localparam int TMO    = 40;

    typedef struct packed {
        logic [OFFS_W-1:0] moffs;
        logic [OFFS_W-1:0] fboffs;
        logic [4:0]        word;
        logic [31:0]       lo;
        logic [15:0]       hi;
    } exp_cmd_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ADDR_W-1:0] src_base = '0;
    logic [OFFS_W-1:0] src_start = '0, dst_start = '0;
    logic [LEN_W-1:0]  xfer_len = '0;
    logic to_imem = 1'b0, secure = 1'b0;
    logic busy, done, cmd_valid, dma_idle;
    logic [1:0] err_code;
    logic [31:0] base_lo;
    logic [15:0] base_hi;
    logic [OFFS_W-1:0] cmd_moffs, cmd_fboffs;
    logic [4:0] cmd_word;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int resp_dly = 1;
    bit hang = 1'b0;
    int dly_cnt = 0;
    int last_cmd_cyc = 0;
    string tag = "R1";
    exp_cmd_t expq[$];

    always #10 clk = ~clk;

    fw_chunk_loader #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .LEN_W(LEN_W), .TMO_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base),
        .src_start(src_start), .dst_start(dst_start), .xfer_len(xfer_len),
        .to_imem(to_imem), .secure(secure), .busy(busy), .done(done),
        .err_code(err_code), .base_lo(base_lo), .base_hi(base_hi),
        .cmd_valid(cmd_valid), .cmd_moffs(cmd_moffs), .cmd_fboffs(cmd_fboffs),
        .cmd_word(cmd_word), .dma_idle(dma_idle)
    );

    // DMA engine model: drops idle the cycle after a command
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dma_idle <= 1'b1;
            dly_cnt  <= 0;
        end else if (cmd_valid) begin
            dma_idle <= 1'b0;
            dly_cnt  <= resp_dly;
        end else if (!dma_idle && !hang) begin
            if (dly_cnt <= 1) dma_idle <= 1'b1;
            else              dly_cnt  <= dly_cnt - 1;
        end
    end

    always @(posedge clk) cycles <= cycles + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops the scoreboard for every command
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            exp_cmd_t got;
            last_cmd_cyc = cycles;
            got = '{moffs: cmd_moffs, fboffs: cmd_fboffs, word: cmd_word, lo: base_lo, hi: base_hi};
            check(dma_idle == 1'b1, "R7", "command while engine busy", 128'(dma_idle), 128'(1));
            if (expq.size() == 0) begin
                check(1'b0, tag, "unexpected command", 128'(got), 128'(0));
            end else begin
                exp_cmd_t e;
                e = expq.pop_front();
                check(got == e, tag, "command fields (R2 R5 R6)", 128'(got), 128'(e));
            end
        end
    end

    task automatic run_load(input logic [ADDR_W-1:0] b, input logic [OFFS_W-1:0] s,
                            input logic [OFFS_W-1:0] d, input logic [LEN_W-1:0] l,
                            input bit im, input bit sc, input int n_exp,
                            input logic [1:0] exp_err, input bit disturb, input string t);
        logic [ADDR_W-1:0] eff;
        logic [OFFS_W-1:0] fb0;
        int waited;
        tag = t;
        eff = im ? b : b + ADDR_W'(s);
        fb0 = im ? s : '0;
        for (int k = 0; k < n_exp; k++) begin
            exp_cmd_t e;
            e.moffs  = d + OFFS_W'(k * 256);
            e.fboffs = fb0 + OFFS_W'(k * 256);
            e.word   = {sc, im, 3'b110};
            e.lo     = 32'(eff >> 8);
            e.hi     = 16'(eff >> 40);
            expq.push_back(e);
        end
        @(negedge clk);
        src_base = b; src_start = s; dst_start = d; xfer_len = l;
        to_imem = im; secure = sc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R13", "busy after start", 128'(busy), 128'(1));
        if (disturb) begin
            src_base = ~b; src_start = s + 32'h80; dst_start = ~d;
            xfer_len = l + 32'h100; to_imem = ~im; secure = ~sc; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waited = 1;
        while (!done && waited < 5000) begin
            @(negedge clk);
            waited++;
        end
        check(done == 1'b1, t, "done seen", 128'(done), 128'(1));
        if (l == 0)
            check(waited == 2, "R10", "zero-length done latency", 128'(waited), 128'(2));
        if (exp_err == 2'd3)
            check(cycles - last_cmd_cyc == TMO + 1, "R11", "timeout latency",
                  128'(cycles - last_cmd_cyc), 128'(TMO + 1));
        check(err_code == exp_err, t, "error code", 128'(err_code), 128'(exp_err));
        check(expq.size() == 0, t, "missing commands", 128'(expq.size()), 128'(0));
        @(negedge clk);
        check(!done && !busy, "R13", "done single pulse / idle after", 128'({done, busy}), 128'(0));
        for (int i = 0; i < 6; i++) @(negedge clk);
        expq.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !cmd_valid, "R1", "reset outputs",
              128'({busy, done, cmd_valid}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !cmd_valid, "R1", "idle after reset",
              128'({busy, done, cmd_valid}), 128'(0));

        // R3 instruction target: tag in source offset, base high field nonzero
        resp_dly = 1;
        run_load(48'h05AB_1234_5600, 32'h300, 32'h100, 32'h400, 1'b1, 1'b1, 4, 2'd0, 1'b0, "R3");
        // R4 data target: start folded into base, source offsets from zero
        resp_dly = 4;
        run_load(48'h0000_0001_1000, 32'h200, 32'h40, 32'h300, 1'b0, 1'b0, 3, 2'd0, 1'b0, "R4");
        // R3 unaligned start is fine for instruction memory
        resp_dly = 2;
        run_load(48'h0000_0000_2000, 32'h80, 32'h0, 32'h100, 1'b1, 1'b0, 1, 2'd0, 1'b0, "R3");
        // R8 same start folded into data base misaligns it
        run_load(48'h0000_0000_2000, 32'h80, 32'h0, 32'h100, 1'b0, 1'b0, 0, 2'd1, 1'b0, "R8");
        // R8 misaligned base, instruction target
        run_load(48'h0000_0000_1010, 32'h0, 32'h0, 32'h200, 1'b1, 1'b1, 0, 2'd1, 1'b0, "R8");
        // R9 misaligned length
        run_load(48'h0000_0000_4000, 32'h0, 32'h0, 32'h180, 1'b1, 1'b0, 0, 2'd2, 1'b0, "R9");
        // R9 both bad: base wins
        run_load(48'h0000_0000_4004, 32'h0, 32'h0, 32'h181, 1'b1, 1'b0, 0, 2'd1, 1'b0, "R9");
        // R10 zero length
        run_load(48'h0000_0000_4000, 32'h0, 32'h0, 32'h0, 1'b0, 1'b1, 0, 2'd0, 1'b0, "R10");
        // R11 hung engine
        hang = 1'b1;
        run_load(48'h0000_0000_8000, 32'h0, 32'h20, 32'h200, 1'b0, 1'b1, 1, 2'd3, 1'b0, "R11");
        hang = 1'b0;
        repeat (10) @(negedge clk);
        // R6 recovery and longer run
        resp_dly = 3;
        run_load(48'h00FF_0000_0000, 32'h0, 32'h1000, 32'h800, 1'b0, 1'b1, 8, 2'd0, 1'b0, "R6");
        // R12 disturbed inputs and extra start pulses
        resp_dly = 5;
        run_load(48'h0000_0003_0000, 32'h100, 32'h200, 32'h300, 1'b1, 1'b0, 3, 2'd0, 1'b1, "R12");
        // R2 secure data load to check the command word bits
        resp_dly = 1;
        run_load(48'h0000_0000_0000, 32'h100, 32'h0, 32'h100, 1'b0, 1'b1, 1, 2'd0, 1'b0, "R2");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule